// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers a set of external interrupt lines and internal request lines, and presents one interrupt output to a single processor. Software configures it through a word-addressed register bus. Each source has its own configuration word. That word holds a mask, a polarity, a choice between level and edge detection, a 4-bit priority and a vector number. Edge events are latched, so a short pulse is not lost.

The processor services an interrupt in two steps. It reads the acknowledge register, which returns the vector of the best deliverable source and moves that source into service. It then writes the end-of-interrupt register, which retires the most recently accepted interrupt. A small stack records which interrupts are in service, so a higher-priority source can nest over one already running. A task-priority threshold blocks low-priority sources. A programmable spurious vector is returned when nothing can be delivered.

When the block leaves reset it is in pass-through mode. In that mode external line 0 drives the processor interrupt directly. Software selects controller mode through the global configuration word, and it can reset the whole controller by writing one bit there.

Top module: `prio_intc`

Register map (word address on `bus_addr`):

| Address | Contents |
|---|---|
| 0x00 | Global configuration word |
| 0x01 | Spurious vector |
| 0x02 | Task priority |
| 0x03 | Acknowledge (read) |
| 0x04 | End of interrupt (write) |
| 0x20 + i | Configuration word of source i |

Source numbering: sources 0 to 4 are `ext_irq[0]` to `ext_irq[4]`, and sources 5 to 8 are `int_req[0]` to `int_req[3]`.

## Requirements
- R1: After reset, every source configuration word reads 0x8000_0000 (only the mask bit set) and the global configuration word reads 0. The task priority reads 15, the spurious vector reads 0xFF, and the block is in pass-through mode.
- R2: In pass-through mode (global configuration bit 29 clear), `irq_out` follows `ext_irq[0]`, and a read of the acknowledge address (0x03) returns the spurious vector.
- R3: In a source configuration word, bit 31 is the mask. A masked source never raises `irq_out` and is never returned by an acknowledge read.
- R4: Bit 23 is the polarity (1 = high level or rising edge, 0 = low level or falling edge). Bit 22 selects level detection (1) or edge detection (0). In edge mode one qualifying transition is latched as a pending request, and a transition in the other direction has no effect.
- R5: Bits 19:16 hold the priority and bits 7:0 hold the vector. An acknowledge read returns the vector of the pending unmasked source with the highest priority. When priorities are equal, the source with the lower index wins.
- R6: A source is delivered only when its priority is strictly greater than the task priority (address 0x02, bits 3:0).
- R7: `irq_out` rises in controller mode only when the best pending priority is greater than the priority at the top of the in-service stack. An acknowledge that returns a vector pushes that source, and the in-service stack holds 4 entries.
- R8: Any write to the end-of-interrupt address (0x04) retires the most recently acknowledged interrupt. A lower-priority source that is still pending is then delivered again.
- R9: An acknowledge read returns the spurious vector (address 0x01, bits 7:0) whenever no source is deliverable. Such a read changes no state.
- R10: Bit 30 of a source configuration word reads 1 while the source is requesting (a latched edge, or an active level, masked or not) or is in service. Writes to bit 30 are ignored.
- R11: Writing 1 to bit 31 of the global configuration word returns the controller to the reset state of R1. This clears the latched edges and the in-service stack.
- R12: Acknowledging an edge-mode source clears its latched request, so it is not delivered again after the end-of-interrupt write. A level-mode source whose input is still active requests again once it is retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_irq | input | 5 | External interrupt lines, synchronous to clk |
| int_req | input | 4 | Internal source request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; has side effects only at the acknowledge address |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Most internal faults show up in the same cycle, either on `irq_out` or in the vector returned by the next acknowledge read. Two kinds of fault take longer to appear. A stack entry that is lost or duplicated shows only on a later end-of-interrupt write, as a wrong nested priority. A latched edge that is not cleared shows as a second delivery after that source has been retired. The bench checks `irq_out` before every bus operation and checks each acknowledged vector against a model. This exposes stack errors within one or two acknowledge and end-of-interrupt pairs. Bit 30 of each source word gives direct visibility of the pending and in-service state.

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int N_EXT     = 5,
  parameter int N_INT     = 4,
  parameter int VEC_W     = 8,
  parameter int PRI_W     = 4,
  parameter int STK_DEPTH = 4,
  parameter int ADDR_W    = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_EXT-1:0]      ext_irq,
  input  logic [N_INT-1:0]      int_req,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  irq_out
);
  localparam int NSRC  = N_EXT + N_INT;
  localparam int IDX_W = $clog2(NSRC);
  localparam int SP_W  = $clog2(STK_DEPTH + 1);
  localparam logic [ADDR_W-1:0] A_GCFG = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SPUR = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_TASK = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_EOI  = ADDR_W'(4);
  localparam logic [ADDR_W-2:0] SRC_LIM = (ADDR_W-1)'(NSRC);
  localparam logic [SP_W-1:0]   SP_FULL = SP_W'(STK_DEPTH);

  logic [NSRC-1:0]  raw, prev_raw, msk, pol, lvl, epend, insvc;
  logic [NSRC-1:0]  line, prev_line, edge_ev, asserted, req, take_oh, epend_nx;
  logic [PRI_W-1:0] pri [NSRC];
  logic [VEC_W-1:0] vec [NSRC];
  logic             mixed;
  logic [VEC_W-1:0] spur;
  logic [PRI_W-1:0] task_pri;
  logic [IDX_W-1:0] stk_src [STK_DEPTH];
  logic [PRI_W-1:0] stk_pri [STK_DEPTH];
  logic [SP_W-1:0]  sp;

  logic             best_vld;
  logic [PRI_W-1:0] best_pri, top_pri;
  logic [IDX_W-1:0] best_idx;
  logic             deliver, ack_take, eoi_wr, soft_rst, src_sel;
  logic [IDX_W-1:0] sidx;
  logic             unused_bits;

  assign raw       = {int_req, ext_irq};
  assign line      = ~(raw ^ pol);
  assign prev_line = ~(prev_raw ^ pol);
  assign edge_ev   = line & ~prev_line & ~lvl;
  assign asserted  = (lvl & line) | (~lvl & epend);
  assign req       = asserted & ~msk & ~insvc;

  always_comb begin
    best_vld = 1'b0;
    best_pri = '0;
    best_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i] && (!best_vld || pri[i] > best_pri)) begin
        best_vld = 1'b1;
        best_pri = pri[i];
        best_idx = IDX_W'(i);
      end
    end
  end

  assign top_pri  = (sp == '0) ? '0 : stk_pri[sp - SP_W'(1)];
  assign deliver  = mixed && best_vld && (best_pri > task_pri) &&
                    (best_pri > top_pri) && (sp < SP_FULL);
  assign irq_out  = mixed ? deliver : ext_irq[0];

  assign src_sel  = bus_addr[ADDR_W-1] && (bus_addr[ADDR_W-2:0] < SRC_LIM);
  assign sidx     = bus_addr[IDX_W-1:0];
  assign ack_take = bus_rd && (bus_addr == A_ACK) && deliver;
  assign eoi_wr   = bus_wr && (bus_addr == A_EOI);
  assign soft_rst = bus_wr && (bus_addr == A_GCFG) && bus_wdata[31];
  assign take_oh  = ack_take ? (NSRC'(1) << best_idx) : '0;
  assign epend_nx = (epend & ~take_oh) | edge_ev;
  assign unused_bits = ^{bus_wdata[30], bus_wdata[28:24], bus_wdata[21:20],
                         bus_wdata[15:VEC_W]};

  always_comb begin
    bus_rdata = '0;
    if (src_sel) begin
      bus_rdata[31]            = msk[sidx];
      bus_rdata[30]            = asserted[sidx] | insvc[sidx];
      bus_rdata[23]            = pol[sidx];
      bus_rdata[22]            = lvl[sidx];
      bus_rdata[16 +: PRI_W]   = pri[sidx];
      bus_rdata[VEC_W-1:0]     = vec[sidx];
    end else begin
      case (bus_addr)
        A_GCFG:  bus_rdata[29]         = mixed;
        A_SPUR:  bus_rdata[VEC_W-1:0]  = spur;
        A_TASK:  bus_rdata[PRI_W-1:0]  = task_pri;
        A_ACK:   bus_rdata[VEC_W-1:0]  = deliver ? vec[best_idx] : spur;
        default: bus_rdata             = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_raw <= '0;
      msk      <= '1;
      pol      <= '0;
      lvl      <= '0;
      epend    <= '0;
      insvc    <= '0;
      mixed    <= 1'b0;
      spur     <= '1;
      task_pri <= '1;
      sp       <= '0;
      for (int i = 0; i < NSRC; i++) begin
        pri[i] <= '0;
        vec[i] <= '0;
      end
      for (int j = 0; j < STK_DEPTH; j++) begin
        stk_src[j] <= '0;
        stk_pri[j] <= '0;
      end
    end else if (soft_rst) begin
      prev_raw <= raw;
      msk      <= '1;
      pol      <= '0;
      lvl      <= '0;
      epend    <= '0;
      insvc    <= '0;
      mixed    <= 1'b0;
      spur     <= '1;
      task_pri <= '1;
      sp       <= '0;
      for (int i = 0; i < NSRC; i++) begin
        pri[i] <= '0;
        vec[i] <= '0;
      end
    end else begin
      prev_raw <= raw;
      epend    <= epend_nx;
      if (bus_wr) begin
        if (src_sel) begin
          msk[sidx] <= bus_wdata[31];
          pol[sidx] <= bus_wdata[23];
          lvl[sidx] <= bus_wdata[22];
          pri[sidx] <= bus_wdata[16 +: PRI_W];
          vec[sidx] <= bus_wdata[VEC_W-1:0];
        end else if (bus_addr == A_GCFG) begin
          mixed <= bus_wdata[29];
        end else if (bus_addr == A_SPUR) begin
          spur <= bus_wdata[VEC_W-1:0];
        end else if (bus_addr == A_TASK) begin
          task_pri <= bus_wdata[PRI_W-1:0];
        end
      end
      if (ack_take) begin
        stk_src[sp[SP_W-1:0]] <= best_idx;
        stk_pri[sp[SP_W-1:0]] <= best_pri;
        sp                    <= sp + SP_W'(1);
        insvc[best_idx]       <= 1'b1;
      end else if (eoi_wr && sp != '0) begin
        sp                             <= sp - SP_W'(1);
        insvc[stk_src[sp - SP_W'(1)]]  <= 1'b0;
      end
    end
  end

  p_stack_tracks_insvc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(insvc) == int'(sp));

  p_stack_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SP_FULL);

  p_ack_push_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !soft_rst) |=> (sp == $past(sp) + SP_W'(1)));

  p_eoi_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && sp != '0 && !ack_take) |=> (sp == $past(sp) - SP_W'(1)));

  p_spurious_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_ACK && !irq_out) |-> (bus_rdata[VEC_W-1:0] == spur));

  p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (sp == '0 && !mixed && msk == '1 && epend == '0));

  p_masked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mixed && msk == '1) |-> !irq_out);
endmodule

// File: tb/test_prio_intc.sv
module test_prio_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  ext_irq = '0;
  logic [3:0]  int_req = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prio_intc i_prio_intc (.clk, .rst_n, .ext_irq, .int_req, .bus_wr, .bus_rd,
                         .bus_addr, .bus_wdata, .bus_rdata, .irq_out);

  // model state for the random phase
  logic       m_msk [9];
  logic [3:0] m_pri [9];
  int         m_stk_src [4];
  int         m_stk_pri [4];
  int         m_sp;
  logic [3:0] m_task;

  function automatic logic [31:0] vpr(logic m, logic a, logic p, logic l,
                                      logic [3:0] pr, logic [7:0] v);
    return {m, a, 6'b0, p, l, 2'b0, pr, 8'b0, v};
  endfunction

  function automatic int m_best(logic [8:0] lines);
    int b = -1;
    for (int i = 0; i < 9; i++) begin
      bit busy = 0;
      for (int k = 0; k < m_sp; k++) if (m_stk_src[k] == i) busy = 1;
      if (lines[i] && !m_msk[i] && !busy && (b < 0 || m_pri[i] > m_pri[b])) b = i;
    end
    return b;
  endfunction

  function automatic bit m_deliver(int b);
    int top = (m_sp == 0) ? 0 : m_stk_pri[m_sp-1];
    return b >= 0 && int'(m_pri[b]) > int'(m_task) && int'(m_pri[b]) > top && m_sp < 4;
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(string r, logic [5:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 chk(r, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic irq_chk(string r, logic exp);
    settle();
    chk(r, {31'b0, irq_out}, {31'b0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk("R1 src0", 6'h20, 32'h8000_0000);
    rd_chk("R1 src8", 6'h28, 32'h8000_0000);
    rd_chk("R1 gcfg", 6'h00, 32'h0);
    rd_chk("R1 task", 6'h02, 32'hF);
    rd_chk("R1 spur", 6'h01, 32'hFF);
    irq_chk("R1 irq", 1'b0);
    // R2 pass-through
    ext_irq[0] = 1'b1;
    irq_chk("R2 irq follows line0", 1'b1);
    rd_chk("R2 ack spurious", 6'h03, 32'hFF);
    ext_irq[0] = 1'b0;
    irq_chk("R2 irq follows line0 low", 1'b0);
    // controller mode
    wr(6'h00, 32'h2000_0000);
    rd_chk("R2 gcfg mode", 6'h00, 32'h2000_0000);
    wr(6'h02, 32'h0);
    wr(6'h21, vpr(1, 0, 1, 1, 4'd5, 8'h11));
    ext_irq[1] = 1'b1;
    irq_chk("R3 masked quiet", 1'b0);
    rd_chk("R10 active while masked", 6'h21, 32'hC0C5_0011);
    rd_chk("R3 masked not acked", 6'h03, 32'hFF);
    wr(6'h21, vpr(0, 1, 1, 1, 4'd5, 8'h11));
    irq_chk("R3 unmasked raises", 1'b1);
    rd_chk("R5 ack vector", 6'h03, 32'h11);
    irq_chk("R7 in service drops irq", 1'b0);
    wr(6'h22, vpr(0, 0, 1, 1, 4'd5, 8'h12));
    ext_irq[2] = 1'b1;
    irq_chk("R7 equal priority blocked", 1'b0);
    wr(6'h23, vpr(0, 0, 1, 1, 4'd9, 8'h13));
    ext_irq[3] = 1'b1;
    irq_chk("R7 higher nests", 1'b1);
    rd_chk("R7 nested ack", 6'h03, 32'h13);
    rd_chk("R10 active in service", 6'h23, 32'h40C9_0013);
    wr(6'h04, 32'h0);
    irq_chk("R12 level re-request", 1'b1);
    ext_irq[3] = 1'b0;
    irq_chk("R8 lower equal still blocked", 1'b0);
    rd_chk("R9 ack spurious", 6'h03, 32'hFF);
    rd_chk("R10 active cleared", 6'h23, 32'h00C9_0013);
    wr(6'h04, 32'h0);
    irq_chk("R8 after second eoi", 1'b1);
    rd_chk("R5 tie lower index", 6'h03, 32'h11);
    wr(6'h04, 32'h0);
    // R6 threshold
    wr(6'h02, 32'h5);
    irq_chk("R6 equal to task blocked", 1'b0);
    rd_chk("R6 ack spurious", 6'h03, 32'hFF);
    wr(6'h02, 32'h4);
    irq_chk("R6 above task", 1'b1);
    rd_chk("R6 ack", 6'h03, 32'h11);
    wr(6'h04, 32'h0);
    ext_irq[3:1] = 3'b0;
    wr(6'h02, 32'h0);
    irq_chk("R6 idle", 1'b0);
    wr(6'h04, 32'h0);
    irq_chk("R8 eoi on empty stack", 1'b0);
    // R4 rising edge
    wr(6'h25, vpr(0, 0, 1, 0, 4'd12, 8'h25));
    int_req[0] = 1'b1; settle();
    int_req[0] = 1'b0;
    irq_chk("R4 rising edge latched", 1'b1);
    rd_chk("R10 latched edge active", 6'h25, 32'h408C_0025);
    rd_chk("R4 edge ack", 6'h03, 32'h25);
    wr(6'h04, 32'h0);
    irq_chk("R12 edge cleared by ack", 1'b0);
    // R4 falling edge
    wr(6'h26, vpr(0, 0, 0, 0, 4'd7, 8'h26));
    int_req[1] = 1'b1;
    irq_chk("R4 rising ignored in falling mode", 1'b0);
    int_req[1] = 1'b0;
    irq_chk("R4 falling edge latched", 1'b1);
    rd_chk("R4 falling ack", 6'h03, 32'h26);
    wr(6'h04, 32'h0);
    // R4 active-low level
    wr(6'h27, vpr(0, 0, 0, 1, 4'd3, 8'h27));
    irq_chk("R4 low level active", 1'b1);
    rd_chk("R4 low level ack", 6'h03, 32'h27);
    wr(6'h04, 32'h0);
    int_req[2] = 1'b1;
    irq_chk("R4 low level released", 1'b0);
    // R11 soft reset
    ext_irq[1] = 1'b1;
    wr(6'h21, vpr(0, 0, 1, 1, 4'd6, 8'h31));
    rd_chk("R11 setup ack", 6'h03, 32'h31);
    wr(6'h00, 32'h8000_0000);
    rd_chk("R11 src5 masked", 6'h25, 32'h8000_0000);
    rd_chk("R11 src1 cleared", 6'h21, 32'h8000_0000);
    rd_chk("R11 gcfg", 6'h00, 32'h0);
    rd_chk("R11 task", 6'h02, 32'hF);
    rd_chk("R11 spur", 6'h01, 32'hFF);
    ext_irq = 5'b00001;
    irq_chk("R11 pass-through again", 1'b1);
    ext_irq = '0; int_req = '0;
    settle();
    // random phase: level, active-high sources
    wr(6'h00, 32'h8000_0000);
    wr(6'h00, 32'h2000_0000);
    wr(6'h01, 32'hEE);
    m_task = 4'($urandom % 3);
    wr(6'h02, {28'b0, m_task});
    for (int i = 0; i < 9; i++) begin
      m_msk[i] = ($urandom % 4) == 0;
      m_pri[i] = 4'($urandom);
      wr(6'(32 + i), vpr(m_msk[i], 0, 1, 1, m_pri[i], 8'(8'h80 + i)));
    end
    m_sp = 0;
    for (int n = 0; n < 80; n++) begin
      logic [8:0] lines = 9'($urandom);
      int b;
      bit d;
      if (n == 40) begin
        m_task = 4'($urandom % 4);
        wr(6'h02, {28'b0, m_task});
      end
      {int_req, ext_irq} = lines;
      settle();
      b = m_best(lines);
      d = m_deliver(b);
      chk("R7 random irq", {31'b0, irq_out}, {31'b0, d});
      if (($urandom % 3) != 0) begin
        rd_chk("R5 random ack", 6'h03, d ? 32'(8'h80 + b) : 32'hEE);
        if (d) begin
          m_stk_src[m_sp] = b;
          m_stk_pri[m_sp] = m_pri[b];
          m_sp++;
        end
      end else begin
        wr(6'h04, $urandom);
        if (m_sp > 0) m_sp--;
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule